// File: doc/BRIEF.md
# Protected Fuse Word Access Controller

This block sits on a simple memory-mapped host bus and gives indirect, key-guarded access to a small one-time-programmable fuse array. The host writes a control word that carries a fuse byte offset, an 8-bit unlock value and a read or program strobe. If the unlock value is correct, the controller runs a timed access against its fuse array. The strobe stays set while the access runs and clears when it completes. The host polls the control register until the strobe clears, then takes the fetched word from the result register.

A program access ORs the contents of the program-data register into the addressed fuse word, so fuse bits can only go from 0 to 1. A second address window serves direct word reads of the low, public fuse words, with no sequencing. The fuse array is a behavioural model that comes out of reset holding a parameter-derived preload pattern.

Top module: `efuse_ctl`

## Requirements
- R1: After reset, the control, program-data and result registers all read zero. Fuse word i holds SEED XOR {i[7:0], i[7:0], i[7:0], i[7:0]}.
- R2: Register map by byte address: control at 0x40, program data at 0x50, result at 0x60. The low two address bits are ignored. Read data appears on `bus_rdata` the cycle after the read is sampled and is zero in cycles with no read. The control register reads back as {8'h00, offset[7:0], key[7:0], 6'b0, read_busy, program_busy}. Bits 23:16 of a control write give the fuse byte offset, bits 15:8 the key, bit 1 the read strobe and bit 0 the program strobe.
- R3: A control write with key 0xAC and bit 1 set starts a read of fuse word offset>>2; the low two offset bits are ignored. Read_busy reads 1 for exactly ACCESS_LAT cycles. When it clears, the result register holds the fuse word, with the byte at the lowest fuse offset in bits 7:0.
- R4: A control write with key 0xAC and only bit 0 set starts a program access. The access captures the program-data register at request time. Program_busy reads 1 for exactly PROG_LAT cycles, and the fuse word then becomes its old value OR the captured data.
- R5: A control write with a key other than 0xAC starts nothing. Both strobe bits read 0 at once, and the result register and the fuse array are unchanged. The offset and key fields are still stored.
- R6: While either strobe is set, control writes are ignored entirely: fields, strobes and results are unaffected. Program-data writes are still accepted.
- R7: A read at byte address 0x200 + 4*i returns fuse word i for i < PUB_WORDS and reflects completed programs.
- R8: Unmapped addresses read zero, including window words i >= PUB_WORDS. A protected read of a word index >= FUSE_WORDS returns zero, and a program of such an index changes no fuse word.
- R9: A control write with both strobes set performs a read only; no fuse word is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |

## Verification
The bench builds the controller with ACCESS_LAT=5 and PROG_LAT=9. With two unequal delays, a read busy window cannot pass for a program window, and the reverse also fails. PUB_WORDS=6 with FUSE_WORDS=16 puts the public window's edge well inside the array. As a result, window word 6 must read zero even though it exists, and protected reads still reach the non-public words. An offset of 0x80 indexes beyond the array, and its low index bits alias word 0. This shows that an out-of-range program cannot disturb that word.

// File: rtl/efuse_pkg.sv
package efuse_pkg;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_READ = 2'd1, OP_PROG = 2'd2} fuse_op_e;

  localparam logic [11:0] CTRL_OFS   = 12'h040;
  localparam logic [11:0] PDATA_OFS  = 12'h050;
  localparam logic [11:0] RESULT_OFS = 12'h060;
  localparam logic [11:0] WIN_OFS    = 12'h200;
  localparam logic [7:0]  UNLOCK_KEY = 8'hAC;

  function automatic logic [31:0] fuse_preload(input logic [31:0] seed, input int idx);
    logic [7:0] b;
    b = idx[7:0];
    return seed ^ {b, b, b, b};
  endfunction
endpackage

// File: rtl/efuse_array.sv
module efuse_array #(
  parameter int          WORDS = 16,
  parameter int          IDXW  = $clog2(WORDS),
  parameter logic [31:0] SEED  = 32'hA5C3_0F00
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDXW-1:0] a_idx,
  output logic [31:0]     a_rdata,
  input  logic            wr_en,
  input  logic [31:0]     wr_bits,
  input  logic [IDXW-1:0] b_idx,
  output logic [31:0]     b_rdata
);
  logic [31:0]      mem_q [WORDS];
  logic [WORDS-1:0] hit;

  for (genvar g = 0; g < WORDS; g++) begin : g_hit
    assign hit[g] = wr_en && (a_idx == IDXW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WORDS; i++) begin
      if (rst)         mem_q[i] <= efuse_pkg::fuse_preload(SEED, i);
      else if (hit[i]) mem_q[i] <= mem_q[i] | wr_bits;
    end
  end

  assign a_rdata = mem_q[a_idx];
  assign b_rdata = mem_q[b_idx];
endmodule

// File: rtl/efuse_seq.sv
module efuse_seq
  import efuse_pkg::*;
#(
  parameter int ACCESS_LAT = 8,
  parameter int PROG_LAT   = 12,
  parameter int IDXW       = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  fuse_op_e        start_op,
  input  logic [IDXW-1:0] start_idx,
  input  logic            start_inr,
  input  logic [31:0]     start_bits,
  output logic            busy_rd,
  output logic            busy_pg,
  output logic            done,
  output logic [IDXW-1:0] cur_idx,
  output logic            cur_inr,
  output logic [31:0]     cur_bits
);
  localparam int MAXLAT = (ACCESS_LAT > PROG_LAT) ? ACCESS_LAT : PROG_LAT;
  localparam int CW     = $clog2(MAXLAT + 1);

  fuse_op_e        op_q;
  logic [CW-1:0]   cnt_q;
  logic [IDXW-1:0] idx_q;
  logic            inr_q;
  logic [31:0]     bits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_NONE;
      cnt_q  <= '0;
      idx_q  <= '0;
      inr_q  <= 1'b0;
      bits_q <= '0;
    end else if (start) begin
      op_q   <= start_op;
      cnt_q  <= (start_op == OP_READ) ? CW'(ACCESS_LAT - 1) : CW'(PROG_LAT - 1);
      idx_q  <= start_idx;
      inr_q  <= start_inr;
      bits_q <= start_bits;
    end else if (done) begin
      op_q   <= OP_NONE;
    end else if (op_q != OP_NONE) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_rd  = (op_q == OP_READ);
  assign busy_pg  = (op_q == OP_PROG);
  assign done     = (op_q != OP_NONE) && (cnt_q == '0);
  assign cur_idx  = idx_q;
  assign cur_inr  = inr_q;
  assign cur_bits = bits_q;
endmodule

// File: rtl/efuse_ctl.sv
module efuse_ctl
  import efuse_pkg::*;
#(
  parameter int          FUSE_WORDS = 16,
  parameter int          PUB_WORDS  = 8,
  parameter int          ACCESS_LAT = 8,
  parameter int          PROG_LAT   = 12,
  parameter int          ADDR_W     = 12,
  parameter logic [31:0] SEED       = 32'hA5C3_0F00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int IDXW = (FUSE_WORDS > 1) ? $clog2(FUSE_WORDS) : 1;
  localparam int WW   = ADDR_W - 2;
  localparam logic [WW-1:0] W_CTRL   = WW'(CTRL_OFS   >> 2);
  localparam logic [WW-1:0] W_PDATA  = WW'(PDATA_OFS  >> 2);
  localparam logic [WW-1:0] W_RESULT = WW'(RESULT_OFS >> 2);
  localparam logic [WW-1:0] W_WIN    = WW'(WIN_OFS    >> 2);
  localparam logic [WW-1:0] PUB_LIM  = WW'(PUB_WORDS);
  localparam logic [6:0]    FW_LIM   = 7'(FUSE_WORDS);

  logic [7:0]  off_q, key_q;
  logic [31:0] pdata_q, result_q, rdata_q;

  logic            seq_busy_rd, seq_busy_pg, seq_done, seq_start, seq_inr;
  logic [IDXW-1:0] seq_idx;
  logic [31:0]     seq_bits;
  logic [31:0]     arr_a_rdata, arr_b_rdata;

  logic [WW-1:0] word_addr, win_word;
  logic          rd_req, wr_req, ctrl_wr, accept, win_hit;
  logic [5:0]    req_word;
  fuse_op_e      req_op;
  logic [31:0]   rd_mux;

  assign word_addr = bus_addr[ADDR_W-1:2];
  assign rd_req    = bus_sel && !bus_we;
  assign wr_req    = bus_sel && bus_we;
  assign ctrl_wr   = wr_req && (word_addr == W_CTRL);
  assign accept    = ctrl_wr && !(seq_busy_rd || seq_busy_pg);
  assign seq_start = accept && (bus_wdata[15:8] == UNLOCK_KEY) && (bus_wdata[1] || bus_wdata[0]);
  assign req_op    = bus_wdata[1] ? OP_READ : OP_PROG;
  assign req_word  = bus_wdata[23:18];

  assign win_word  = word_addr - W_WIN;
  assign win_hit   = (word_addr >= W_WIN) && (win_word < PUB_LIM);

  efuse_seq #(.ACCESS_LAT(ACCESS_LAT), .PROG_LAT(PROG_LAT), .IDXW(IDXW)) seq_i (
    .clk(clk), .rst(rst),
    .start(seq_start), .start_op(req_op),
    .start_idx(IDXW'(req_word)), .start_inr({1'b0, req_word} < FW_LIM),
    .start_bits(pdata_q),
    .busy_rd(seq_busy_rd), .busy_pg(seq_busy_pg), .done(seq_done),
    .cur_idx(seq_idx), .cur_inr(seq_inr), .cur_bits(seq_bits)
  );

  efuse_array #(.WORDS(FUSE_WORDS), .IDXW(IDXW), .SEED(SEED)) arr_i (
    .clk(clk), .rst(rst),
    .a_idx(seq_idx), .a_rdata(arr_a_rdata),
    .wr_en(seq_done && seq_busy_pg && seq_inr), .wr_bits(seq_bits),
    .b_idx(IDXW'(win_word)), .b_rdata(arr_b_rdata)
  );

  always_comb begin
    rd_mux = '0;
    if (word_addr == W_CTRL)        rd_mux = {8'h00, off_q, key_q, 6'b0, seq_busy_rd, seq_busy_pg};
    else if (word_addr == W_PDATA)  rd_mux = pdata_q;
    else if (word_addr == W_RESULT) rd_mux = result_q;
    else if (win_hit)               rd_mux = arr_b_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q    <= '0;
      key_q    <= '0;
      pdata_q  <= '0;
      result_q <= '0;
      rdata_q  <= '0;
    end else begin
      if (accept) begin
        off_q <= bus_wdata[23:16];
        key_q <= bus_wdata[15:8];
      end
      if (wr_req && (word_addr == W_PDATA)) pdata_q <= bus_wdata;
      if (seq_done && seq_busy_rd)          result_q <= seq_inr ? arr_a_rdata : 32'h0;
      rdata_q <= rd_req ? rd_mux : 32'h0;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/efuse_ctl_chk.sv
module efuse_ctl_chk #(
  parameter int ACCESS_LAT = 8,
  parameter int PROG_LAT   = 12
) (
  input logic        clk,
  input logic        rst,
  input logic        busy_rd,
  input logic        busy_pg,
  input logic        done,
  input logic        start,
  input logic [31:0] result
);
  logic [15:0] span_q;

  always_ff @(posedge clk) begin
    if (rst)                         span_q <= '0;
    else if (start)                  span_q <= 16'd1;
    else if ((busy_rd || busy_pg) && !done) span_q <= span_q + 16'd1;
  end

  assert_one_op_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy_rd, busy_pg}));

  assert_start_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    start |-> !(busy_rd || busy_pg));

  assert_read_window_R3: assert property (@(posedge clk) disable iff (rst)
    (done && busy_rd) |-> (span_q == 16'(ACCESS_LAT)));

  assert_prog_window_R4: assert property (@(posedge clk) disable iff (rst)
    (done && busy_pg) |-> (span_q == 16'(PROG_LAT)));

  assert_read_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_rd && !done) |=> busy_rd);

  assert_result_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !(done && busy_rd) |=> $stable(result));
endmodule

bind efuse_ctl efuse_ctl_chk #(.ACCESS_LAT(ACCESS_LAT), .PROG_LAT(PROG_LAT)) chk_i (
  .clk(clk), .rst(rst), .busy_rd(seq_busy_rd), .busy_pg(seq_busy_pg),
  .done(seq_done), .start(seq_start), .result(result_q)
);

// File: tb/efuse_ctl_tb.sv
`timescale 1ns/1ps
module efuse_ctl_tb_top;
  localparam int          FW   = 16;
  localparam int          PW   = 6;
  localparam int          AL   = 5;
  localparam int          PL   = 9;
  localparam logic [31:0] SEED = 32'hA5C3_0F00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0, errs = 0;
  string req_tag = "R1";

  always #2 clk = ~clk;

  efuse_ctl #(.FUSE_WORDS(FW), .PUB_WORDS(PW), .ACCESS_LAT(AL), .PROG_LAT(PL),
              .ADDR_W(12), .SEED(SEED)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  // behavioural reference state
  logic [31:0] m_fuse [FW];
  logic [7:0]  m_off, m_key;
  logic [31:0] m_pdata, m_result, m_pd;
  int          m_op, m_cnt, m_idx;
  logic        m_inr;

  function automatic logic [31:0] preload(input int i);
    logic [7:0] b;
    b = i[7:0];
    return SEED ^ {b, b, b, b};
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int w;
    w = int'(a >> 2);
    if (w == 'h10) return {8'h00, m_off, m_key, 6'b0, m_op == 1, m_op == 2};
    if (w == 'h14) return m_pdata;
    if (w == 'h18) return m_result;
    if (w >= 'h80 && (w - 'h80) < PW) return m_fuse[w - 'h80];
    return 32'h0;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%08h expected=%08h", req_tag, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, advance model through the edge, compare at next negedge
  task automatic cyc(input logic s, input logic w, input logic [11:0] a, input logic [31:0] d);
    logic [31:0] exp, pd_pre;
    bit busy_pre;
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
    exp = (s && !w) ? model_read(a) : 32'h0;
    busy_pre = (m_op != 0);
    pd_pre = m_pdata;
    if (m_op != 0 && m_cnt == 0) begin
      if (m_op == 1) m_result = m_inr ? m_fuse[m_idx] : 32'h0;
      else if (m_inr) m_fuse[m_idx] = m_fuse[m_idx] | m_pd;
      m_op = 0;
    end else if (m_op != 0) m_cnt--;
    if (s && w && (a >> 2) == 12'h010 && !busy_pre) begin
      m_off = d[23:16];
      m_key = d[15:8];
      if (d[15:8] == 8'hAC && d[1:0] != 2'b00) begin
        m_op  = d[1] ? 1 : 2;
        m_cnt = (m_op == 1) ? AL - 1 : PL - 1;
        m_idx = int'(d[23:18]) % FW;
        m_inr = int'(d[23:18]) < FW;
        m_pd  = pd_pre;
      end
    end
    if (s && w && (a >> 2) == 12'h014) m_pdata = d;
    @(negedge clk);
    check(bus_rdata, exp);
  endtask

  task automatic rd(input logic [11:0] a);
    cyc(1'b1, 1'b0, a, 32'h0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b1, a, d);
  endtask

  task automatic poll_done();
    for (int i = 0; i < 64; i++) begin
      rd(12'h040);
      if (bus_rdata[1:0] == 2'b00) break;
    end
  endtask

  initial begin
    #800000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int polls;
    for (int i = 0; i < FW; i++) m_fuse[i] = preload(i);
    m_off = 0; m_key = 0; m_pdata = 0; m_result = 0; m_pd = 0;
    m_op = 0; m_cnt = 0; m_idx = 0; m_inr = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state and preload pattern
    req_tag = "R1";
    rd(12'h040); rd(12'h050); rd(12'h060);
    for (int i = 0; i < PW; i++) rd(12'h200 + 12'(4 * i));
    check(bus_rdata, preload(PW - 1));

    // R2: field placement and readback, no strobe
    req_tag = "R2";
    wr(12'h050, 32'h0000_F0F1);
    rd(12'h050); rd(12'h052);
    wr(12'h040, 32'h0014_AC00);
    rd(12'h040);
    check(bus_rdata, 32'h0014_AC00);
    cyc(1'b0, 1'b0, 12'h000, 32'h0);

    // R3: protected read of non-public word 7, busy for exactly AL polls
    req_tag = "R3";
    wr(12'h040, 32'h001C_AC02);
    polls = 0;
    for (int i = 0; i < 64; i++) begin
      rd(12'h040);
      if (bus_rdata[1] == 1'b1) polls++;
      else break;
    end
    check(32'(polls), 32'(AL));
    rd(12'h060);
    check(bus_rdata, preload(7));
    wr(12'h040, 32'h001E_AC02);   // low offset bits ignored: same word
    poll_done();
    rd(12'h060);
    check(bus_rdata, preload(7));

    // R4: program word 2, data captured at request despite a later pdata write
    req_tag = "R4";
    wr(12'h040, 32'h0008_AC01);
    wr(12'h050, 32'hFFFF_FFFF);
    polls = 0;
    for (int i = 0; i < 64; i++) begin
      rd(12'h040);
      if (bus_rdata[0] == 1'b1) polls++;
      else break;
    end
    check(32'(polls), 32'(PL - 1));
    rd(12'h208);
    check(bus_rdata, preload(2) | 32'h0000_F0F1);

    // R5: wrong key leaves strobes, result and fuses alone
    req_tag = "R5";
    wr(12'h050, 32'h0F00_0000);
    wr(12'h040, 32'h0000_AB03);
    rd(12'h040);
    check(bus_rdata, 32'h0000_AB00);
    rd(12'h060);
    check(bus_rdata, preload(7));
    rd(12'h200);
    check(bus_rdata, preload(0));

    // R6: control write during busy is dropped
    req_tag = "R6";
    wr(12'h040, 32'h000C_AC02);
    wr(12'h040, 32'h0010_AC02);
    rd(12'h040);
    poll_done();
    rd(12'h040);
    check(bus_rdata, 32'h000C_AC00);
    rd(12'h060);
    check(bus_rdata, preload(3));

    // R7: window tracks programmed content
    req_tag = "R7";
    wr(12'h040, 32'h0014_AC01);
    poll_done();
    rd(12'h214);
    check(bus_rdata, preload(5) | 32'h0F00_0000);

    // R8: unmapped addresses and out-of-range indices
    req_tag = "R8";
    rd(12'h044); rd(12'h100); rd(12'h200 + 12'(4 * PW));
    check(bus_rdata, 32'h0);
    wr(12'h040, 32'h0080_AC02);
    poll_done();
    rd(12'h060);
    check(bus_rdata, 32'h0);
    wr(12'h050, 32'hFFFF_0000);
    wr(12'h040, 32'h0080_AC01);
    poll_done();
    rd(12'h200);
    check(bus_rdata, preload(0));

    // R9: both strobes: read only
    req_tag = "R9";
    wr(12'h040, 32'h0004_AC03);
    poll_done();
    rd(12'h060);
    check(bus_rdata, preload(1));
    rd(12'h204);
    check(bus_rdata, preload(1));

    repeat (3) cyc(1'b0, 1'b0, 12'h000, 32'h0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule